// File: doc/BRIEF.md
# Front-End Readout Sequencer

This block runs a multiplexed sixteen-channel analog front-end chip through repeated readout cycles. The chip has one serial control line, and that line carries three kinds of pulse. A trigger pulse starts the chip's internal logic. A hold pulse freezes the shaped peaks. Then a train of multiplexer pulses steps the chip through its low-gain values and then its high-gain values. After the last value the sequencer asserts the chip reset line. Each multiplexer pulse is followed by a convert strobe to the ADC and then a write strobe to the downstream averaging data path. The data path receives one clear strobe at the start of every burst.

A board controller sets a hold-to-readout delay, a mode code and a low-gain-only option, then pulses `start`. The sequencer latches these settings and runs a burst of identical cycles, 256 by default. It keeps `busy` high for the whole burst. Stretching the delay lets software measure how far the held value droops. The mode code selects which charge injector, anode or dynode, is fired together with each trigger pulse.

Top module: `fe_readout_seq`

## Requirements
- R1: Each cycle puts the pulses on `chipClk` in this order: one one-cycle trigger pulse, one one-cycle hold pulse, then 2*NUM_CH multiplexer pulses. The first NUM_CH multiplexer pulses read low gain and the rest read high gain.
- R2: The hold pulse rises TH_GAP+1 clock cycles after the trigger pulse rises. With the default TH_GAP=19 at 200 MHz, that gap is 100 ns.
- R3: The first multiplexer pulse rises `holdDelay`+1 low cycles after the hold pulse ends. `holdDelay` is 13 bits wide.
- R4: Each multiplexer pulse period is MUX_DIV cycles. The line is high for the first MUX_DIV/2 cycles of the period and low for the rest. The default of 134 keeps the pulse rate under 1.5 MHz at 200 MHz.
- R5: `adcConv` is high for one cycle at period phase MUX_DIV/2, which is the first low cycle. `dpWr` is high for one cycle at the phase after that.
- R6: `chipRst` is high for RST_LEN cycles directly after the last multiplexer period. When `lowGainOnly` is 1, the last period is the NUM_CH-th one, so the high-gain pulses are skipped.
- R7: One accepted start runs exactly NUM_CYCLES cycles back to back. Mode, delay and the low-gain option are latched at start, so changes to these inputs during a burst have no effect on it.
- R8: `dpRst` is high once per burst, in the trigger cycle of the first cycle of the burst.
- R9: The injector outputs pulse together with each trigger pulse, according to the mode code. `aciTrig` pulses for modes 0 and 4. `dciTrig` pulses for mode 6. Neither pulses for modes 1, 2, 3, 5 or 7.
- R10: `busy` rises on the cycle after an accepted start and falls after the last reset cycle of the burst. A start that is seen while `busy` is high is ignored, including one seen in the final reset cycle.
- R11: While `rstN` is low, and whenever the block is idle, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Burst request pulse from the board controller |
| holdDelay | input | DLY_W | Number of extra cycles between the hold pulse and the first multiplexer pulse |
| mode | input | 3 | Mode code that selects the injector |
| lowGainOnly | input | 1 | When 1, the sequencer reads the low-gain values only |
| chipClk | output | 1 | Shared trigger, hold and multiplexer line to the chip |
| chipRst | output | 1 | Chip memory reset |
| adcConv | output | 1 | ADC convert strobe |
| dpWr | output | 1 | Data path write strobe |
| dpRst | output | 1 | Data path clear strobe, once per burst |
| aciTrig | output | 1 | Anode charge injector trigger |
| dciTrig | output | 1 | Dynode charge injector trigger |
| busy | output | 1 | Burst in progress |

## Verification
The bench runs bursts in every injector class: anode modes, the dynode mode, and modes that fire no injector. This shows that the injector decode follows the latched code and not the live one. It uses a zero delay and longer hold delays to separate the R3 window from the fixed trigger-to-hold gap. It alternates full reads with low-gain-only reads, which shows whether the reset follows the sixteenth or the thirty-second pulse. It also sends starts in mid-burst, in the exact final reset cycle, and right after the block goes idle, which pins down the edges at which `busy` accepts a request.

// File: rtl/fe_seq_pkg.sv
package fe_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TRIG,
    ST_GAP,
    ST_HOLD,
    ST_DLY,
    ST_MUX,
    ST_RST
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latch;      // capture settings, clear cycle count
    logic loadGap;    // arm the trigger-to-hold timer
    logic loadDly;    // arm the hold-to-readout timer
    logic loadRst;    // arm the chip reset timer
    logic nextCycle;  // one readout cycle finished
    logic trigPulse;  // trigger phase on the chip line
    logic holdPulse;  // hold phase on the chip line
    logic inMux;      // multiplexer train running
    logic rstPhase;   // chip reset phase
    logic busy;
  } seqStrobe_t;

  function automatic logic anodeMode(input logic [2:0] m);
    return (m == 3'd0) || (m == 3'd4);
  endfunction

  function automatic logic dynodeMode(input logic [2:0] m);
    return (m == 3'd6);
  endfunction

endpackage

// File: rtl/fe_seq_ctrl.sv
module fe_seq_ctrl
  import fe_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       tmrZero,
  input  logic       muxDone,
  input  logic       burstDone,
  output seqStrobe_t stb
);

  seqState_e state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    stb      = '0;
    stb.busy = (state != ST_IDLE);
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          stb.latch = 1'b1;
          stateNxt  = ST_TRIG;
        end
      end
      ST_TRIG: begin
        stb.trigPulse = 1'b1;
        stb.loadGap   = 1'b1;
        stateNxt      = ST_GAP;
      end
      ST_GAP: begin
        if (tmrZero) stateNxt = ST_HOLD;
      end
      ST_HOLD: begin
        stb.holdPulse = 1'b1;
        stb.loadDly   = 1'b1;
        stateNxt      = ST_DLY;
      end
      ST_DLY: begin
        if (tmrZero) stateNxt = ST_MUX;
      end
      ST_MUX: begin
        stb.inMux = 1'b1;
        if (muxDone) begin
          stb.loadRst = 1'b1;
          stateNxt    = ST_RST;
        end
      end
      ST_RST: begin
        stb.rstPhase = 1'b1;
        if (tmrZero) begin
          stb.nextCycle = 1'b1;
          stateNxt      = burstDone ? ST_IDLE : ST_TRIG;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/fe_seq_dpath.sv
module fe_seq_dpath
  import fe_seq_pkg::*;
#(
  parameter int NUM_CH     = 16,
  parameter int DLY_W      = 13,
  parameter int MUX_DIV    = 134,
  parameter int TH_GAP     = 19,
  parameter int NUM_CYCLES = 256,
  parameter int RST_LEN    = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       stb,
  input  logic [DLY_W-1:0] holdDelay,
  input  logic [2:0]       mode,
  input  logic             lowGainOnly,
  output logic             tmrZero,
  output logic             muxDone,
  output logic             burstDone,
  output logic             chipClk,
  output logic             chipRst,
  output logic             adcConv,
  output logic             dpWr,
  output logic             dpRst,
  output logic             aciTrig,
  output logic             dciTrig,
  output logic             busy
);

  localparam int NUM_MUX = 2 * NUM_CH;
  localparam int MUX_W   = $clog2(NUM_MUX);
  localparam int PH_W    = $clog2(MUX_DIV);
  localparam int CYC_W   = $clog2(NUM_CYCLES);
  localparam int HALF    = MUX_DIV / 2;
  localparam logic [DLY_W-1:0] GAP_LD  = DLY_W'(TH_GAP - 1);
  localparam logic [DLY_W-1:0] RST_LD  = DLY_W'(RST_LEN - 1);
  localparam logic [PH_W-1:0]  PH_LAST = PH_W'(MUX_DIV - 1);

  logic [2:0]       modeQ;
  logic             lgQ;
  logic [DLY_W-1:0] dlyQ;
  logic [DLY_W-1:0] tmr;
  logic [PH_W-1:0]  ph;
  logic [MUX_W-1:0] muxIdx;
  logic [CYC_W-1:0] cyc;
  logic [MUX_W-1:0] lastIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= '0;
      lgQ   <= 1'b0;
      dlyQ  <= '0;
    end else if (stb.latch) begin
      modeQ <= mode;
      lgQ   <= lowGainOnly;
      dlyQ  <= holdDelay;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              tmr <= '0;
    else if (stb.loadGap)   tmr <= GAP_LD;
    else if (stb.loadDly)   tmr <= dlyQ;
    else if (stb.loadRst)   tmr <= RST_LD;
    else if (tmr != '0)     tmr <= tmr - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ph     <= '0;
      muxIdx <= '0;
    end else if (!stb.inMux) begin
      ph     <= '0;
      muxIdx <= '0;
    end else if (ph == PH_LAST) begin
      ph     <= '0;
      muxIdx <= muxIdx + 1'b1;
    end else begin
      ph <= ph + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cyc <= '0;
    else if (stb.latch)     cyc <= '0;
    else if (stb.nextCycle) cyc <= cyc + 1'b1;
  end

  assign lastIdx   = lgQ ? MUX_W'(NUM_CH - 1) : MUX_W'(NUM_MUX - 1);
  assign tmrZero   = (tmr == '0);
  assign muxDone   = stb.inMux && (ph == PH_LAST) && (muxIdx == lastIdx);
  assign burstDone = (cyc == CYC_W'(NUM_CYCLES - 1));

  assign chipClk = stb.trigPulse || stb.holdPulse ||
                   (stb.inMux && (ph < PH_W'(HALF)));
  assign chipRst = stb.rstPhase;
  assign adcConv = stb.inMux && (ph == PH_W'(HALF));
  assign dpWr    = stb.inMux && (ph == PH_W'(HALF + 1));
  assign dpRst   = stb.trigPulse && (cyc == '0);
  assign aciTrig = stb.trigPulse && anodeMode(modeQ);
  assign dciTrig = stb.trigPulse && dynodeMode(modeQ);
  assign busy    = stb.busy;

endmodule

// File: rtl/fe_readout_seq.sv
module fe_readout_seq
  import fe_seq_pkg::*;
#(
  parameter int NUM_CH     = 16,
  parameter int DLY_W      = 13,
  parameter int MUX_DIV    = 134,  // at least 4
  parameter int TH_GAP     = 19,   // at least 1
  parameter int NUM_CYCLES = 256,  // at least 2
  parameter int RST_LEN    = 4     // at least 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [DLY_W-1:0] holdDelay,
  input  logic [2:0]       mode,
  input  logic             lowGainOnly,
  output logic             chipClk,
  output logic             chipRst,
  output logic             adcConv,
  output logic             dpWr,
  output logic             dpRst,
  output logic             aciTrig,
  output logic             dciTrig,
  output logic             busy
);

  seqStrobe_t stb;
  logic       tmrZero;
  logic       muxDone;
  logic       burstDone;

  fe_seq_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .tmrZero   (tmrZero),
    .muxDone   (muxDone),
    .burstDone (burstDone),
    .stb       (stb)
  );

  fe_seq_dpath #(
    .NUM_CH     (NUM_CH),
    .DLY_W      (DLY_W),
    .MUX_DIV    (MUX_DIV),
    .TH_GAP     (TH_GAP),
    .NUM_CYCLES (NUM_CYCLES),
    .RST_LEN    (RST_LEN)
  ) dpath_i (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .holdDelay   (holdDelay),
    .mode        (mode),
    .lowGainOnly (lowGainOnly),
    .tmrZero     (tmrZero),
    .muxDone     (muxDone),
    .burstDone   (burstDone),
    .chipClk     (chipClk),
    .chipRst     (chipRst),
    .adcConv     (adcConv),
    .dpWr        (dpWr),
    .dpRst       (dpRst),
    .aciTrig     (aciTrig),
    .dciTrig     (dciTrig),
    .busy        (busy)
  );

endmodule

// File: rtl/fe_readout_seq_chk.sv
module fe_readout_seq_chk (
  input logic clk,
  input logic rstN,
  input logic chipClk,
  input logic chipRst,
  input logic adcConv,
  input logic dpWr,
  input logic dpRst,
  input logic aciTrig,
  input logic dciTrig,
  input logic busy
);

  // R8
  burst_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> dpRst && chipClk);

  // R9
  inj_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (aciTrig || dciTrig) |-> chipClk && !(aciTrig && dciTrig));

  // R5
  conv_then_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    adcConv |=> dpWr && !adcConv && !chipClk);

  // R6
  rst_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    chipRst |-> busy && !chipClk && !adcConv && !dpWr);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !chipClk && !chipRst && !adcConv && !dpWr && !dpRst);

  // R10
  busy_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(chipRst));

endmodule

bind fe_readout_seq fe_readout_seq_chk chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .chipClk (chipClk),
  .chipRst (chipRst),
  .adcConv (adcConv),
  .dpWr    (dpWr),
  .dpRst   (dpRst),
  .aciTrig (aciTrig),
  .dciTrig (dciTrig),
  .busy    (busy)
);

// File: tb/fe_readout_seq_tb.sv
module fe_readout_seq_tb_top;

  localparam int NCH   = 16;
  localparam int DW    = 13;
  localparam int MDIV  = 4;
  localparam int GAP   = 3;
  localparam int NCYC  = 3;
  localparam int RLEN  = 2;
  localparam int HALFP = MDIV / 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [DW-1:0] holdDelay = '0;
  logic [2:0]    mode = '0;
  logic          lowGainOnly = 1'b0;
  logic chipClk, chipRst, adcConv, dpWr, dpRst, aciTrig, dciTrig, busy;

  int checks = 0;
  int fails  = 0;
  logic [7:0] expQ[$];
  logic       lastBusy = 1'b0;

  always #2.5 clk = ~clk;

  fe_readout_seq #(
    .NUM_CH(NCH), .DLY_W(DW), .MUX_DIV(MDIV), .TH_GAP(GAP),
    .NUM_CYCLES(NCYC), .RST_LEN(RLEN)
  ) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .holdDelay(holdDelay),
    .mode(mode), .lowGainOnly(lowGainOnly), .chipClk(chipClk),
    .chipRst(chipRst), .adcConv(adcConv), .dpWr(dpWr), .dpRst(dpRst),
    .aciTrig(aciTrig), .dciTrig(dciTrig), .busy(busy)
  );

  // vector: {busy,dciTrig,aciTrig,dpRst,dpWr,adcConv,chipRst,chipClk}
  function automatic logic [7:0] mk(input logic c, input logic r, input logic cv,
                                    input logic w, input logic dr, input logic a,
                                    input logic d, input logic b);
    return {b, d, a, dr, w, cv, r, c};
  endfunction

  function automatic string reqOf(input int bitIdx);
    case (bitIdx)
      0: return "R1 R2 R3 R4 chipClk";
      1: return "R6 chipRst";
      2: return "R5 adcConv";
      3: return "R5 dpWr";
      4: return "R8 dpRst";
      5: return "R9 aciTrig";
      6: return "R9 dciTrig";
      default: return "R10 busy";
    endcase
  endfunction

  // R7: one burst of NCYC cycles, with the settings captured at start
  task automatic pushBurst(input logic [2:0] m, input logic lg, input int dly);
    int nMux = lg ? NCH : 2 * NCH;
    logic a = (m == 3'd0) || (m == 3'd4);
    logic d = (m == 3'd6);
    for (int c = 0; c < NCYC; c++) begin
      expQ.push_back(mk(1, 0, 0, 0, c == 0, a, d, 1));
      for (int g = 0; g < GAP; g++) expQ.push_back(mk(0, 0, 0, 0, 0, 0, 0, 1));
      expQ.push_back(mk(1, 0, 0, 0, 0, 0, 0, 1));
      for (int g = 0; g <= dly; g++) expQ.push_back(mk(0, 0, 0, 0, 0, 0, 0, 1));
      for (int k = 0; k < nMux; k++)
        for (int p = 0; p < MDIV; p++)
          expQ.push_back(mk(p < HALFP, 0, p == HALFP, p == HALFP + 1, 0, 0, 0, 1));
      for (int g = 0; g < RLEN; g++) expQ.push_back(mk(0, 1, 0, 0, 0, 0, 0, 1));
    end
  endtask

  function automatic logic [7:0] actual();
    return {busy, dciTrig, aciTrig, dpRst, dpWr, adcConv, chipRst, chipClk};
  endfunction

  task automatic tick();
    logic [7:0] e;
    logic [7:0] a;
    @(negedge clk);
    e = (expQ.size() != 0) ? expQ.pop_front() : 8'h00;
    a = actual();
    checks++;
    if (a !== e) begin
      fails++;
      for (int i = 0; i < 8; i++)
        if (a[i] !== e[i])
          $display("FAIL %s at %0t: actual %b expected %b", reqOf(i), $time, a[i], e[i]);
    end
    lastBusy = e[7];
  endtask

  task automatic issueStart(input logic [2:0] m, input logic lg, input int dly);
    mode        = m;
    lowGainOnly = lg;
    holdDelay   = DW'(dly);
    start       = 1'b1;
    if (!lastBusy) pushBurst(m, lg, dly);  // R10: accepted only when idle
    tick();
    start = 1'b0;
  endtask

  task automatic drain();
    while (expQ.size() != 0) tick();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    // R11: outputs low during reset
    for (int i = 0; i < 4; i++) tick();
    @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < 3; i++) tick();

    // R1 R3 R9: full read, anode mode 0, zero delay
    issueStart(3'd0, 1'b0, 0);
    drain();
    tick();

    // R6: low gain only, anode mode 4, long delay; R7: inputs change mid-burst
    issueStart(3'd4, 1'b1, 9);
    for (int i = 0; i < 20; i++) tick();
    mode = 3'd6; lowGainOnly = 1'b0; holdDelay = 13'd1;
    for (int i = 0; i < 30; i++) tick();
    // R10: start while busy is ignored
    issueStart(3'd6, 1'b0, 2);
    drain();

    // R10: start in the final reset cycle is ignored
    issueStart(3'd6, 1'b0, 2);
    drain();
    issueStart(3'd3, 1'b0, 0);
    drain();
    tick();

    // R10: start on the first idle cycle is accepted
    issueStart(3'd5, 1'b1, 1);
    drain();
    tick();
    issueStart(3'd6, 1'b1, 4);
    drain();
    for (int i = 0; i < 3; i++) tick();

    // R9: mode 2 fires no injector
    issueStart(3'd2, 1'b1, 0);
    drain();
    for (int i = 0; i < 3; i++) tick();

    summary();
    $finish;
  end

endmodule